// File: doc/BRIEF.md
# Byte-wide arithmetic and logic unit with a status-flag register

This block is the arithmetic and logic stage of a small 8-bit processor core. Each cycle with `opValid` high, it applies one operation to two byte operands and presents the byte result in the same cycle. The first operand is the destination register and the second is either a source register or an immediate. The block also holds six status flags in a register: carry, zero, negative, two's complement overflow, signed and half carry. At the clock edge that ends an accepted operation, it rewrites only the flags that the operation is defined to touch.

The carry used by the carry-consuming operations and the zero flag used by the chained subtractions both come from this flag register. A multi-byte add, subtract or compare can therefore be issued one byte per cycle, from the low byte up, with nothing held outside the block. Instruction decoding, word-wide arithmetic, multiplication and memory access belong to other blocks.

Top module: `alu8_flags`

## Requirements
- R1: After reset the flag register `flags` reads 0. Its bit positions are fixed: bit 0 carry (C), bit 1 zero (Z), bit 2 negative (N), bit 3 overflow (V), bit 4 signed (S), bit 5 half carry (H). `result` is combinational in the cycle `opValid` is high. `flags` changes only at the rising edge that ends a valid operation. Opcodes 17 to 31 write nothing and change no flag.
- R2: Opcode 0 computes A+B and opcode 1 computes A+B+C. Both write the result and update C (carry out of bit 7), Z, N (bit 7 of the result), V (signed overflow), S and H (carry out of bit 3).
- R3: Opcode 2 computes A-B and opcode 3 computes A-B-C. Both write the result. They update C (borrow out of bit 7), Z, N, V (signed overflow), S and H (borrow into bit 4 from the low nibble).
- R4: Opcode 4 compares A with B and opcode 5 compares A with B and the carry. They update the same flags as opcodes 2 and 3 with the same values, and `resultWrite` stays low.
- R5: For opcodes 3 and 5, Z becomes 1 only if the result is zero and Z was already 1. A nonzero result clears Z.
- R6: Opcodes 6, 7 and 8 compute A AND B, A OR B and A XOR B. They write the result, update Z and N, clear V, set S = N, and leave C and H unchanged.
- R7: Opcode 9 writes 0xFF minus A, sets C, clears V, updates Z, N and S, and leaves H unchanged.
- R8: Opcode 10 writes 0x00 minus A. It sets C unless A is zero, sets V only for A = 0x80, sets H unless the low nibble of A is zero, and updates Z, N and S.
- R9: Opcode 11 shifts A left with a 0 into bit 0 and bit 7 into C. Opcode 12 shifts A right with a 0 into bit 7 and bit 0 into C. Both update Z, N, V = N xor C and S, and leave H unchanged.
- R10: Opcode 13 shifts A left with C into bit 0 and bit 7 into C. Opcode 14 shifts A right with C into bit 7 and bit 0 into C. Flags are updated as in R9.
- R11: Opcode 15 shifts A right, keeps bit 7 and moves bit 0 into C. Flags are updated as in R9.
- R12: Opcode 16 writes A with its two nibbles exchanged and changes no flag.
- R13: At every clock after reset, S equals N xor V.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 5 | Operation selector, values per requirements |
| opA | input | 8 | First operand (destination register value) |
| opB | input | 8 | Second operand (register or immediate) |
| result | output | 8 | Operation result, combinational |
| resultWrite | output | 1 | Result should be written back this cycle |
| flagMask | output | 6 | Flags the current operation updates, flag bit layout |
| flags | output | 6 | Registered status flags |

## Verification
`result`, `resultWrite` and `flagMask` follow the inputs in the same cycle. The bench drives each operation just after a falling edge and reads these outputs one nanosecond later, which is well before the next rising edge. The flag update lands at the rising edge that follows, so `flags` is read one nanosecond after that edge and compared with the reference value advanced by exactly one operation. Because the carry and the sticky zero are taken from the register, each operation's expected result depends on the flags the model computed for the operation before it. Directed chains of carries and compares exercise this dependence, and so does a long random stream of operations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int FLAG_W = 6;
  localparam int OPC_W  = 5;

  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  localparam logic [FLAG_W-1:0] MASK_ARITH = 6'b111111;
  localparam logic [FLAG_W-1:0] MASK_LOGIC = 6'b011110;
  localparam logic [FLAG_W-1:0] MASK_SHIFT = 6'b011111;
  localparam logic [FLAG_W-1:0] MASK_NONE  = 6'b000000;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CP   = 5'd4,
    OP_CPC  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_EOR  = 5'd8,
    OP_COM  = 5'd9,
    OP_NEG  = 5'd10,
    OP_LSL  = 5'd11,
    OP_LSR  = 5'd12,
    OP_ROL  = 5'd13,
    OP_ROR  = 5'd14,
    OP_ASR  = 5'd15,
    OP_SWAP = 5'd16
  } aluOp_e;

  typedef enum logic [1:0] {
    SEL_ADDER,
    SEL_LOGIC,
    SEL_SHIFT,
    SEL_SWAP
  } unitSel_e;

  typedef enum logic [1:0] {
    LF_AND,
    LF_OR,
    LF_XOR,
    LF_NOT
  } logicFn_e;

  typedef enum logic [1:0] {
    FILL_ZERO,
    FILL_CARRY,
    FILL_SIGN
  } shiftFill_e;

  typedef struct packed {
    unitSel_e          unitSel;
    logicFn_e          logicFn;
    logic              isSub;
    logic              useCarry;
    logic              negateA;
    logic              stickyZ;
    logic              shiftRight;
    shiftFill_e        shiftFill;
    logic              writeRes;
    logic [FLAG_W-1:0] updMask;
  } aluCtrl_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [OPC_W-1:0] opCode,
  output aluCtrl_t         ctrl
);

  always_comb begin
    ctrl            = '0;
    ctrl.unitSel    = SEL_ADDER;
    ctrl.logicFn    = LF_AND;
    ctrl.shiftFill  = FILL_ZERO;
    ctrl.updMask    = MASK_NONE;
    ctrl.writeRes   = 1'b0;
    unique case (opCode)
      OP_ADD: begin
        ctrl.writeRes = 1'b1;
        ctrl.updMask  = MASK_ARITH;
      end
      OP_ADC: begin
        ctrl.useCarry = 1'b1;
        ctrl.writeRes = 1'b1;
        ctrl.updMask  = MASK_ARITH;
      end
      OP_SUB: begin
        ctrl.isSub    = 1'b1;
        ctrl.writeRes = 1'b1;
        ctrl.updMask  = MASK_ARITH;
      end
      OP_SBC: begin
        ctrl.isSub    = 1'b1;
        ctrl.useCarry = 1'b1;
        ctrl.stickyZ  = 1'b1;
        ctrl.writeRes = 1'b1;
        ctrl.updMask  = MASK_ARITH;
      end
      OP_CP: begin
        ctrl.isSub    = 1'b1;
        ctrl.updMask  = MASK_ARITH;
      end
      OP_CPC: begin
        ctrl.isSub    = 1'b1;
        ctrl.useCarry = 1'b1;
        ctrl.stickyZ  = 1'b1;
        ctrl.updMask  = MASK_ARITH;
      end
      OP_AND, OP_OR, OP_EOR: begin
        ctrl.unitSel  = SEL_LOGIC;
        ctrl.logicFn  = (opCode == OP_AND) ? LF_AND :
                        (opCode == OP_OR)  ? LF_OR  : LF_XOR;
        ctrl.writeRes = 1'b1;
        ctrl.updMask  = MASK_LOGIC;
      end
      OP_COM: begin
        ctrl.unitSel  = SEL_LOGIC;
        ctrl.logicFn  = LF_NOT;
        ctrl.writeRes = 1'b1;
        ctrl.updMask  = MASK_SHIFT;
      end
      OP_NEG: begin
        ctrl.isSub    = 1'b1;
        ctrl.negateA  = 1'b1;
        ctrl.writeRes = 1'b1;
        ctrl.updMask  = MASK_ARITH;
      end
      OP_LSL, OP_ROL: begin
        ctrl.unitSel   = SEL_SHIFT;
        ctrl.shiftFill = (opCode == OP_ROL) ? FILL_CARRY : FILL_ZERO;
        ctrl.writeRes  = 1'b1;
        ctrl.updMask   = MASK_SHIFT;
      end
      OP_LSR, OP_ROR, OP_ASR: begin
        ctrl.unitSel    = SEL_SHIFT;
        ctrl.shiftRight = 1'b1;
        ctrl.shiftFill  = (opCode == OP_ROR) ? FILL_CARRY :
                          (opCode == OP_ASR) ? FILL_SIGN  : FILL_ZERO;
        ctrl.writeRes   = 1'b1;
        ctrl.updMask    = MASK_SHIFT;
      end
      OP_SWAP: begin
        ctrl.unitSel  = SEL_SWAP;
        ctrl.writeRes = 1'b1;
      end
      default: ctrl.writeRes = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu8_dpath.sv
module alu8_dpath
  import alu8_pkg::*;
(
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic              carryIn,
  input  logic              zeroIn,
  output logic [DATA_W-1:0] resOut,
  output logic [FLAG_W-1:0] flagsOut
);

  logic [DATA_W-1:0] addX, addY, bPick;
  logic              carryTerm, addCin;
  logic [DATA_W:0]   sumWide;
  logic [NIB_W:0]    sumNib;
  logic              addC, addH, addV;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] shiftRes;
  logic              shiftC, fillBit;
  logic              newC, newV, newH, newN, newZ;

  // adder shared by add, subtract, compare and negate
  always_comb begin
    bPick     = ctrl.negateA ? srcA : srcB;
    addX      = ctrl.negateA ? '0 : srcA;
    addY      = ctrl.isSub ? ~bPick : bPick;
    carryTerm = ctrl.useCarry & carryIn;
    addCin    = ctrl.isSub ? ~carryTerm : carryTerm;
    sumWide   = {1'b0, addX} + {1'b0, addY} + (DATA_W+1)'(addCin);
    sumNib    = {1'b0, addX[NIB_W-1:0]} + {1'b0, addY[NIB_W-1:0]} + (NIB_W+1)'(addCin);
    addC      = sumWide[DATA_W] ^ ctrl.isSub;
    addH      = sumNib[NIB_W] ^ ctrl.isSub;
    addV      = (addX[DATA_W-1] == addY[DATA_W-1]) &&
                (sumWide[DATA_W-1] != addX[DATA_W-1]);
  end

  always_comb begin
    unique case (ctrl.logicFn)
      LF_AND:  logicRes = srcA & srcB;
      LF_OR:   logicRes = srcA | srcB;
      LF_XOR:  logicRes = srcA ^ srcB;
      default: logicRes = ~srcA;
    endcase
  end

  always_comb begin
    unique case (ctrl.shiftFill)
      FILL_CARRY: fillBit = carryIn;
      FILL_SIGN:  fillBit = srcA[DATA_W-1];
      default:    fillBit = 1'b0;
    endcase
    if (ctrl.shiftRight) begin
      shiftRes = {fillBit, srcA[DATA_W-1:1]};
      shiftC   = srcA[0];
    end else begin
      shiftRes = {srcA[DATA_W-2:0], fillBit};
      shiftC   = srcA[DATA_W-1];
    end
  end

  always_comb begin
    newC = 1'b0;
    newV = 1'b0;
    newH = 1'b0;
    unique case (ctrl.unitSel)
      SEL_ADDER: begin
        resOut = sumWide[DATA_W-1:0];
        newC   = addC;
        newV   = addV;
        newH   = addH;
      end
      SEL_LOGIC: begin
        resOut = logicRes;
        newC   = 1'b1;
      end
      SEL_SHIFT: begin
        resOut = shiftRes;
        newC   = shiftC;
        newV   = shiftRes[DATA_W-1] ^ shiftC;
      end
      default: resOut = {srcA[NIB_W-1:0], srcA[DATA_W-1:NIB_W]};
    endcase
    newN = resOut[DATA_W-1];
    newZ = (resOut == '0) && (!ctrl.stickyZ || zeroIn);
    flagsOut     = '0;
    flagsOut[FC] = newC;
    flagsOut[FZ] = newZ;
    flagsOut[FN] = newN;
    flagsOut[FV] = newV;
    flagsOut[FS] = newN ^ newV;
    flagsOut[FH] = newH;
  end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OPC_W-1:0]  opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              resultWrite,
  output logic [FLAG_W-1:0] flagMask,
  output logic [FLAG_W-1:0] flags
);

  aluCtrl_t          ctrlBus;
  logic [FLAG_W-1:0] flagNext;

  alu8_ctrl u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrlBus)
  );

  alu8_dpath u_dpath (
    .ctrl     (ctrlBus),
    .srcA     (opA),
    .srcB     (opB),
    .carryIn  (flags[FC]),
    .zeroIn   (flags[FZ]),
    .resOut   (result),
    .flagsOut (flagNext)
  );

  assign resultWrite = opValid & ctrlBus.writeRes;
  assign flagMask    = ctrlBus.updMask;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          flags[i] <= 1'b0;
      else if (opValid && flagMask[i])    flags[i] <= flagNext[i];
    end
  end

  p_sign_is_n_xor_v_r13: assert property (@(posedge clk) disable iff (!rstN)
    flags[FS] == (flags[FN] ^ flags[FV]));

  p_swap_keeps_flags_r12: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_SWAP) |=> $stable(flags));

  p_logic_keeps_ch_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_AND || opCode == OP_OR || opCode == OP_EOR))
      |=> ($stable(flags[FC]) && $stable(flags[FH])));

  p_sticky_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_SBC || opCode == OP_CPC) && !flags[FZ])
      |=> !flags[FZ]);

  p_compare_no_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_CP || opCode == OP_CPC)) |-> !resultWrite);

  p_unused_code_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode > OP_SWAP) |=> $stable(flags));

endmodule

// File: tb/alu8_flags_tb_top.sv
`timescale 1ns/1ps
module alu8_flags_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [7:0] result;
  logic       resultWrite;
  logic [5:0] flagMask;
  logic [5:0] flags;

  int total = 0;
  int bad = 0;
  logic [5:0] modelFlags = '0;

  always #5 clk = ~clk;

  alu8_flags dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .result(result), .resultWrite(resultWrite),
    .flagMask(flagMask), .flags(flags)
  );

  function automatic string reqOf(input int op);
    case (op)
      0, 1:            return "R2";
      2:               return "R3";
      3:               return "R3/R5";
      4:               return "R4";
      5:               return "R4/R5";
      6, 7, 8:         return "R6";
      9:               return "R7";
      10:              return "R8";
      11, 12:          return "R9";
      13, 14:          return "R10";
      15:              return "R11";
      16:              return "R12";
      default:         return "R1";
    endcase
  endfunction

  function automatic int sx(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // reference: computes result, write enable, and new flag values under a mask
  task automatic model(input int op, input int a, input int b,
                       output int res, output bit wr, output logic [5:0] msk,
                       output logic [5:0] nf);
    int c, z, ci, t, sv;
    bit fc, fv, fh, fz, fn;
    c = modelFlags[0]; z = modelFlags[1];
    fc = 0; fv = 0; fh = 0; res = 0; wr = 0; msk = 6'b000000;
    fz = 0;
    case (op)
      0, 1: begin
        ci = (op == 1) ? c : 0;
        t = a + b + ci; res = t % 256; fc = (t > 255);
        fh = ((a % 16) + (b % 16) + ci) > 15;
        sv = sx(a) + sx(b) + ci; fv = (sv > 127) || (sv < -128);
        wr = 1; msk = 6'b111111;
      end
      2, 3, 4, 5: begin
        ci = (op == 3 || op == 5) ? c : 0;
        t = a - b - ci; res = (t + 512) % 256; fc = (t < 0);
        fh = ((a % 16) - (b % 16) - ci) < 0;
        sv = sx(a) - sx(b) - ci; fv = (sv > 127) || (sv < -128);
        wr = (op == 2 || op == 3); msk = 6'b111111;
      end
      6: begin res = a & b; wr = 1; msk = 6'b011110; end
      7: begin res = a | b; wr = 1; msk = 6'b011110; end
      8: begin res = a ^ b; wr = 1; msk = 6'b011110; end
      9: begin res = 255 - a; fc = 1; wr = 1; msk = 6'b011111; end
      10: begin
        res = (256 - a) % 256; fc = (a != 0); fv = (a == 128);
        fh = (a % 16) != 0; wr = 1; msk = 6'b111111;
      end
      11, 12, 13, 14, 15: begin
        case (op)
          11: begin res = (a * 2) % 256;     fc = a >= 128; end
          12: begin res = a / 2;             fc = a % 2; end
          13: begin res = (a * 2) % 256 + c; fc = a >= 128; end
          14: begin res = a / 2 + 128 * c;  fc = a % 2; end
          default: begin res = a / 2 + (a / 128) * 128; fc = a % 2; end
        endcase
        fv = (res >= 128) ^ fc; wr = 1; msk = 6'b011111;
      end
      16: begin res = (a % 16) * 16 + a / 16; wr = 1; end
      default: wr = 0;
    endcase
    fn = res >= 128;
    fz = (res == 0) && ((op != 3 && op != 5) || z == 1);
    nf = {fh, fn ^ fv, fv, fn, fz, fc};
  endtask

  task automatic doOp(input int op, input int a, input int b);
    int eRes; bit eWr; logic [5:0] eMsk, eNew, nextF;
    string rq;
    @(negedge clk);
    opValid = 1'b1; opCode = op[4:0]; opA = a[7:0]; opB = b[7:0];
    #1;
    model(op, a, b, eRes, eWr, eMsk, eNew);
    rq = reqOf(op);
    check(rq, "resultWrite", int'(resultWrite), int'(eWr));
    if (eWr) check(rq, "result", int'(result), eRes);
    nextF = (modelFlags & ~eMsk) | (eNew & eMsk);
    @(posedge clk);
    #1;
    modelFlags = nextF;
    check(rq, "flags", int'(flags), int'(modelFlags));
    if (flags[4] != (flags[2] ^ flags[3]))
      check("R13", "S vs N^V", int'(flags[4]), int'(flags[2] ^ flags[3]));
  endtask

  initial begin : watchdog
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset flags", int'(flags), 0);
    @(negedge clk); rstN = 1'b1;
    // R2 add patterns: half carry, signed overflow, carry with zero, carry chain
    doOp(0, 8'h0F, 8'h01);
    doOp(0, 8'h7F, 8'h01);
    doOp(0, 8'hFF, 8'h01);
    doOp(1, 8'h10, 8'h20);
    doOp(1, 8'h10, 8'h20);
    // R3 subtract: nibble borrow, signed overflow, borrow chain
    doOp(2, 8'h10, 8'h01);
    doOp(2, 8'h80, 8'h01);
    doOp(2, 8'h00, 8'h01);
    doOp(3, 8'h05, 8'h04);
    // R4/R5 chained compares: low differs, high equal after borrow keeps Z=0
    doOp(4, 8'h12, 8'h13);
    doOp(5, 8'h05, 8'h04);
    doOp(4, 8'h33, 8'h33);
    doOp(5, 8'h44, 8'h44);
    doOp(3, 8'h44, 8'h45);
    // R6 logic keeps C/H set earlier
    doOp(0, 8'hFF, 8'hFF);
    doOp(6, 8'hF0, 8'h0F);
    doOp(7, 8'h80, 8'h01);
    doOp(8, 8'hAA, 8'hAA);
    // R7 / R8
    doOp(9, 8'hFF, 8'h00);
    doOp(10, 8'h80, 8'h00);
    doOp(10, 8'h00, 8'h00);
    doOp(10, 8'h01, 8'h00);
    // R9 / R10 / R11 shifts
    doOp(11, 8'h81, 8'h00);
    doOp(13, 8'h40, 8'h00);
    doOp(12, 8'h01, 8'h00);
    doOp(14, 8'h02, 8'h00);
    doOp(15, 8'h81, 8'h00);
    doOp(15, 8'h7E, 8'h00);
    // R12 swap and unused codes (R1)
    doOp(16, 8'h3C, 8'h00);
    doOp(20, 8'h11, 8'h22);
    doOp(31, 8'h00, 8'h00);
    // random stream across all codes
    for (int i = 0; i < 4000; i++) begin
      doOp($urandom_range(0, 19), $urandom_range(0, 255), $urandom_range(0, 255));
    end
    @(negedge clk); opValid = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule